// File: doc/BRIEF.md
# Single-Cycle Fully Associative Translation Cache

This block is a small translation cache that sits in front of one level-one cache, either on the instruction side or on the data side. It checks every stored page in parallel and, in the same cycle as the request, returns the physical address that the cache uses for its tag compare. In that same cycle it judges the access against the domain setting of the page and its permission bits. A violation is reported on the abort output that matches the side the block serves.

On a miss the requester is stalled. The block asks a backing translation store for the missing page over a valid/ready request channel. When the answer arrives it writes the answer into one of its entries and serves the held request in the following cycle. It prefers an empty slot as the victim and falls back to a rotating pointer when every slot is full. It drops every entry when a maintenance operation on the backing store occurs, and also when any of six translation-control registers is written.

Top module: `utlb_top`

## Requirements
- R1: After reset every entry is invalid, `refill_req_valid` is low, and the first request misses (`req_stall` high, `resp_valid` low).
- R2: When a valid request matches a valid entry and no refill is in progress, `resp_valid` is high and `req_stall` is low in that same cycle. `resp_pa` is then the entry's physical page number joined with the low `PAGE_W` bits of `req_va`.
- R3: A request that misses raises `req_stall`. From the next cycle `refill_req_valid` stays high, with `refill_req_vpn` equal to the upper `VA_W-PAGE_W` bits of the request, until a cycle in which `refill_req_ready` is high.
- R4: After the handshake, the first cycle with `rsp_valid` high stores `rsp_ppn`, `rsp_dom` and `rsp_ap` for the requested page. The held request is served in the next cycle.
- R5: The permission field is 4 bits: bit 0 privileged read, bit 1 privileged write, bit 2 user read, bit 3 user write, with 1 meaning allowed. For a client domain an access faults when the bit selected by `req_priv` and `req_write` is 0.
- R6: `dacr` holds 2 bits per domain d at bits [2d+1:2d]. Code 01 is client (the R5 check applies), 11 is manager (never faults), and 00 and 10 always fault.
- R7: With `IS_INSTR`=0 a fault is reported on `dabort` and `pabort` stays low. With `IS_INSTR`=1 it is reported on `pabort`, `dabort` stays low, and `req_write` is ignored (every fetch is checked as a read).
- R8: A refill goes to the lowest-index invalid entry when one exists. Otherwise it goes to the entry named by a rotating pointer that starts at 0 after reset and steps by one, wrapping after `ENTRIES-1`, on each refill into a full table.
- R9: A cycle with `maint_op` high invalidates every entry from the next cycle on.
- R10: A cycle with any bit of `ctl_wr` high invalidates every entry from the next cycle on. The bits are 0 context ID, 1 domain control, 2 primary remap, 3 normal remap, 4 table base 0 and 5 table base 1.
- R11: A refill answer that arrives in a flush cycle is discarded. The block returns to idle, so the held request misses again and issues a fresh refill request.
- R12: The table holds `ENTRIES` distinct pages at once, and after they are filled all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| dacr | input | 2*2**DOM_W | Domain access codes, two bits per domain |
| maint_op | input | 1 | Backing-store maintenance operation, flushes all entries |
| ctl_wr | input | 6 | Translation-control register write strobes, any bit flushes |
| resp_valid | output | 1 | Request served this cycle |
| resp_pa | output | PA_W | Physical address |
| pabort | output | 1 | Permission fault, instruction side |
| dabort | output | 1 | Permission fault, data side |
| req_stall | output | 1 | Request held this cycle |
| refill_req_valid | output | 1 | Refill request to the backing store |
| refill_req_ready | input | 1 | Backing store accepts the refill request |
| refill_req_vpn | output | VA_W-PAGE_W | Page requested |
| rsp_valid | input | 1 | Refill answer present |
| rsp_ppn | input | PA_W-PAGE_W | Answer physical page number |
| rsp_dom | input | DOM_W | Answer domain number |
| rsp_ap | input | 4 | Answer permission bits |

## Verification
The bench builds two copies at the default 10 entries, 32-bit addresses, 4 KiB pages and 16 domains. One copy is data side (`IS_INSTR`=0) and one is instruction side (`IS_INSTR`=1), and both are driven by the same stimulus and refill responses. At 10 entries a pool of 14 pages is enough to push the table into round-robin eviction and pointer wrap. The paired build shows the abort routing and the ignored write flag on identical entries. The responder's random ready and answer delays, together with random flushes, make a flush land on an answer cycle both by chance and on purpose.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    // refill sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    // two-bit domain access codes
    localparam logic [1:0] DOM_NOACC   = 2'b00;
    localparam logic [1:0] DOM_CLIENT  = 2'b01;
    localparam logic [1:0] DOM_MANAGER = 2'b11;

    // permission field: [0] priv rd, [1] priv wr, [2] user rd, [3] user wr
    localparam int AP_W  = 4;
    // translation-control write strobes
    localparam int CTL_N = 6;

endpackage

// File: rtl/utlb_entry_array.sv
module utlb_entry_array
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 10,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int DOM_W   = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 fill_en_i,
    input  logic [IDX_W-1:0]     fill_idx_i,
    input  logic [VPN_W-1:0]     fill_vpn_i,
    input  logic [PPN_W-1:0]     fill_ppn_i,
    input  logic [DOM_W-1:0]     fill_dom_i,
    input  logic [AP_W-1:0]      fill_ap_i,
    input  logic [VPN_W-1:0]     look_vpn_i,
    output logic                 hit_o,
    output logic [PPN_W-1:0]     hit_ppn_o,
    output logic [DOM_W-1:0]     hit_dom_o,
    output logic [AP_W-1:0]      hit_ap_o,
    output logic [ENTRIES-1:0]   valid_o
);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0][DOM_W-1:0] dom;
        logic [ENTRIES-1:0][AP_W-1:0]  ap;
    } table_t;

    table_t tab_q, tab_d;
    logic [ENTRIES-1:0] match;

    always_comb begin
        tab_d = tab_q;
        if (fill_en_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_idx_i == IDX_W'(i)) begin
                    tab_d.valid[i] = 1'b1;
                    tab_d.vpn[i]   = fill_vpn_i;
                    tab_d.ppn[i]   = fill_ppn_i;
                    tab_d.dom[i]   = fill_dom_i;
                    tab_d.ap[i]    = fill_ap_i;
                end
            end
        end
        if (flush_i) begin
            tab_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    // parallel compare, one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tab_q.valid[g] && (tab_q.vpn[g] == look_vpn_i);
    end

    always_comb begin
        hit_ppn_o = '0;
        hit_dom_o = '0;
        hit_ap_o  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_ppn_o = hit_ppn_o | tab_q.ppn[i];
                hit_dom_o = hit_dom_o | tab_q.dom[i];
                hit_ap_o  = hit_ap_o  | tab_q.ap[i];
            end
        end
    end

    assign hit_o   = |match;
    assign valid_o = tab_q.valid;

    // a page lives in at most one slot, so the OR mux never blends entries
    assert_single_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // a flush empties the table at the next edge
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_o == '0));

    // a fill without flush leaves its slot valid
    assert_fill_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en_i && !flush_i) |=> valid_o[$past(fill_idx_i)]);

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int ENTRIES = 10,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               take_i,
    output logic [IDX_W-1:0]   victim_o
);

    typedef struct packed {
        logic [IDX_W-1:0] rr;
    } vic_t;

    vic_t v_q, v_d;
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    // lowest-index empty slot
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        v_d = v_q;
        if (take_i && !any_free) begin
            if (v_q.rr == IDX_W'(ENTRIES - 1)) begin
                v_d.rr = '0;
            end else begin
                v_d.rr = v_q.rr + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign victim_o = any_free ? free_idx : v_q.rr;

    assert_victim_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(victim_o) < ENTRIES);

    // a fill into a table with room never overwrites a live slot
    assert_prefer_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !(&valid_i)) |-> !valid_i[victim_o]);

endmodule

// File: rtl/utlb_perm.sv
module utlb_perm
    import utlb_pkg::*;
#(
    parameter int DOM_W    = 4,
    parameter bit IS_INSTR = 1'b0,
    localparam int DOM_N   = 2 ** DOM_W
) (
    input  logic [2*DOM_N-1:0] dacr_i,
    input  logic [DOM_W-1:0]   dom_i,
    input  logic [AP_W-1:0]    ap_i,
    input  logic               priv_i,
    input  logic               write_i,
    output logic               fault_o
);

    logic [1:0] code;
    logic       eff_wr;
    logic [1:0] sel;

    always_comb begin
        code = dacr_i[{dom_i, 1'b0} +: 2];
        // a fetch is always a read
        eff_wr = IS_INSTR ? 1'b0 : write_i;
        sel    = {~priv_i, eff_wr};
        case (code)
            DOM_CLIENT:  fault_o = ~ap_i[sel];
            DOM_MANAGER: fault_o = 1'b0;
            default:     fault_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/utlb_top.sv
module utlb_top
    import utlb_pkg::*;
#(
    parameter int ENTRIES  = 10,
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int PAGE_W   = 12,
    parameter int DOM_W    = 4,
    parameter bit IS_INSTR = 1'b0,
    localparam int VPN_W   = VA_W - PAGE_W,
    localparam int PPN_W   = PA_W - PAGE_W,
    localparam int DOM_N   = 2 ** DOM_W,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic               req_write,
    input  logic               req_priv,
    input  logic [2*DOM_N-1:0] dacr,
    input  logic               maint_op,
    input  logic [CTL_N-1:0]   ctl_wr,
    output logic               resp_valid,
    output logic [PA_W-1:0]    resp_pa,
    output logic               pabort,
    output logic               dabort,
    output logic               req_stall,
    output logic               refill_req_valid,
    input  logic               refill_req_ready,
    output logic [VPN_W-1:0]   refill_req_vpn,
    input  logic               rsp_valid,
    input  logic [PPN_W-1:0]   rsp_ppn,
    input  logic [DOM_W-1:0]   rsp_dom,
    input  logic [AP_W-1:0]    rsp_ap
);

    typedef struct packed {
        seq_state_e       st;
        logic [VPN_W-1:0] vpn;
    } seq_t;

    seq_t s_q, s_d;

    logic               flush;
    logic               fill_en;
    logic [VPN_W-1:0]   look_vpn;
    logic               hit;
    logic [PPN_W-1:0]   hit_ppn;
    logic [DOM_W-1:0]   hit_dom;
    logic [AP_W-1:0]    hit_ap;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim;
    logic               fault;
    logic               served;

    assign flush    = maint_op | (|ctl_wr);
    assign look_vpn = req_va[VA_W-1:PAGE_W];

    utlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .DOM_W   (DOM_W)
    ) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .fill_en_i  (fill_en),
        .fill_idx_i (victim),
        .fill_vpn_i (s_q.vpn),
        .fill_ppn_i (rsp_ppn),
        .fill_dom_i (rsp_dom),
        .fill_ap_i  (rsp_ap),
        .look_vpn_i (look_vpn),
        .hit_o      (hit),
        .hit_ppn_o  (hit_ppn),
        .hit_dom_o  (hit_dom),
        .hit_ap_o   (hit_ap),
        .valid_o    (valid_vec)
    );

    utlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_vic (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_vec),
        .take_i   (fill_en),
        .victim_o (victim)
    );

    utlb_perm #(
        .DOM_W    (DOM_W),
        .IS_INSTR (IS_INSTR)
    ) u_perm (
        .dacr_i  (dacr),
        .dom_i   (hit_dom),
        .ap_i    (hit_ap),
        .priv_i  (req_priv),
        .write_i (req_write),
        .fault_o (fault)
    );

    // refill sequencer
    always_comb begin
        s_d     = s_q;
        fill_en = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid && !hit) begin
                    s_d.st  = ST_ASK;
                    s_d.vpn = look_vpn;
                end
            end
            ST_ASK: begin
                if (refill_req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    s_d.st  = ST_IDLE;
                    fill_en = !flush;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, vpn: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign served           = req_valid && hit && (s_q.st == ST_IDLE);
    assign resp_valid       = served;
    assign req_stall        = req_valid && !served;
    assign resp_pa          = {hit_ppn, req_va[PAGE_W-1:0]};
    assign refill_req_valid = (s_q.st == ST_ASK);
    assign refill_req_vpn   = s_q.vpn;

    if (IS_INSTR) begin : g_iside
        assign pabort = served && fault;
        assign dabort = 1'b0;
    end else begin : g_dside
        assign pabort = 1'b0;
        assign dabort = served && fault;
    end

    assert_ask_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req_valid && !refill_req_ready) |=>
            (refill_req_valid && $stable(refill_req_vpn)));

    assert_miss_asks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stall && s_q.st == ST_IDLE) |=>
            (refill_req_valid && refill_req_vpn == $past(look_vpn)));

    assert_served_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_stall);

    assert_abort_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pabort || dabort) |-> resp_valid);

    assert_discard_on_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT && rsp_valid && flush) |=>
            (valid_vec == '0 && s_q.st == ST_IDLE));

endmodule

// File: tb/tb_utlb_top.sv
module tb_utlb_top;

    localparam int N      = 10;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int PAGE_W = 12;
    localparam int DOM_W  = 4;
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PPN_W  = PA_W - PAGE_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             req_valid, req_write, req_priv;
    logic [VA_W-1:0]  req_va;
    logic [31:0]      dacr;
    logic             maint_op;
    logic [5:0]       ctl_wr;
    logic             refill_req_ready, rsp_valid;
    logic [PPN_W-1:0] rsp_ppn;
    logic [DOM_W-1:0] rsp_dom;
    logic [3:0]       rsp_ap;

    logic             d_rv, d_pab, d_dab, d_stall, d_rqv;
    logic [PA_W-1:0]  d_pa;
    logic [VPN_W-1:0] d_rvpn;
    logic             i_rv, i_pab, i_dab, i_stall, i_rqv;
    logic [PA_W-1:0]  i_pa;
    logic [VPN_W-1:0] i_rvpn;

    utlb_top #(.ENTRIES(N), .IS_INSTR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_priv(req_priv), .dacr(dacr),
        .maint_op(maint_op), .ctl_wr(ctl_wr), .resp_valid(d_rv), .resp_pa(d_pa),
        .pabort(d_pab), .dabort(d_dab), .req_stall(d_stall),
        .refill_req_valid(d_rqv), .refill_req_ready(refill_req_ready),
        .refill_req_vpn(d_rvpn), .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn),
        .rsp_dom(rsp_dom), .rsp_ap(rsp_ap));

    utlb_top #(.ENTRIES(N), .IS_INSTR(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_priv(req_priv), .dacr(dacr),
        .maint_op(maint_op), .ctl_wr(ctl_wr), .resp_valid(i_rv), .resp_pa(i_pa),
        .pabort(i_pab), .dabort(i_dab), .req_stall(i_stall),
        .refill_req_valid(i_rqv), .refill_req_ready(refill_req_ready),
        .refill_req_vpn(i_rvpn), .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn),
        .rsp_dom(rsp_dom), .rsp_ap(rsp_ap));

    int vectors = 0;
    int fails   = 0;

    // behavioural reference
    bit               m_v   [N];
    logic [VPN_W-1:0] m_vpn [N];
    logic [PPN_W-1:0] m_ppn [N];
    logic [3:0]       m_dom [N];
    logic [3:0]       m_ap  [N];
    int               m_rr;
    int               m_st;      // 0 idle, 1 asking, 2 waiting
    logic [VPN_W-1:0] m_req;
    bit               m_replay;

    // responder
    bit               hs_seen;
    logic [VPN_W-1:0] hs_vpn;
    bit               waiting;
    int               delay;
    int               rsp_cnt = 0;
    bit               flush_on_rsp = 1'b0;
    logic [19:0]      salt = 20'h0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_fault(input logic [3:0] dom, input logic [3:0] ap,
                                     input logic [31:0] dv, input bit priv, input bit wr);
        logic [1:0] code;
        int         idx;
        code = 2'((dv >> (2 * int'(dom))) & 32'h3);
        if (code == 2'b11) return 1'b0;
        if (code != 2'b01) return 1'b1;
        idx = (priv ? 0 : 2) + (wr ? 1 : 0);
        return !ap[idx];
    endfunction

    function automatic logic [VPN_W-1:0] pool(input int k);
        return VPN_W'(20'h00400 + k * 20'h11);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            m_rr = 0; m_st = 0; m_replay = 1'b0; hs_seen = 1'b0;
        end else begin
            int          hi;
            bit          mhit, full, exp_rv, exp_st, fd, fi, flush;
            string       tv, tf;
            logic [VPN_W-1:0] vpn;
            vpn  = req_va[VA_W-1:PAGE_W];
            hi   = 0; mhit = 1'b0; full = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && m_vpn[i] == vpn) begin mhit = 1'b1; hi = i; end
                if (!m_v[i]) full = 1'b0;
            end
            exp_rv = req_valid && m_st == 0 && mhit;
            exp_st = req_valid && !exp_rv;
            tv = m_replay ? "R4 replay" : (full ? "R8 eviction" : "R2 lookup");
            chk(d_rv == exp_rv, tv, 64'(d_rv), 64'(exp_rv));
            chk(i_rv == exp_rv, tv, 64'(i_rv), 64'(exp_rv));
            chk(d_stall == exp_st, "R3 stall", 64'(d_stall), 64'(exp_st));
            chk(i_stall == exp_st, "R3 stall", 64'(i_stall), 64'(exp_st));
            if (exp_rv) begin
                logic [PA_W-1:0] epa;
                epa = {m_ppn[hi], req_va[PAGE_W-1:0]};
                chk(d_pa == epa, "R2 pa", 64'(d_pa), 64'(epa));
                chk(i_pa == epa, "R2 pa", 64'(i_pa), 64'(epa));
                fd = ref_fault(m_dom[hi], m_ap[hi], dacr, req_priv, req_write);
                fi = ref_fault(m_dom[hi], m_ap[hi], dacr, req_priv, 1'b0);
                tf = (((dacr >> (2 * int'(m_dom[hi]))) & 32'h3) == 32'h1) ? "R5 perm" : "R6 domain";
                chk(d_dab == fd, tf, 64'(d_dab), 64'(fd));
                chk(i_pab == fi, "R7 fetch abort", 64'(i_pab), 64'(fi));
            end else begin
                chk(d_dab == 1'b0, "R5 no abort", 64'(d_dab), 64'd0);
                chk(i_pab == 1'b0, "R7 no abort", 64'(i_pab), 64'd0);
            end
            chk(d_pab == 1'b0, "R7 data side pabort", 64'(d_pab), 64'd0);
            chk(i_dab == 1'b0, "R7 instr side dabort", 64'(i_dab), 64'd0);
            chk(d_rqv == (m_st == 1), "R3 refill valid", 64'(d_rqv), 64'(m_st == 1));
            chk(i_rqv == (m_st == 1), "R3 refill valid", 64'(i_rqv), 64'(m_st == 1));
            if (m_st == 1) begin
                chk(d_rvpn == m_req, "R3 refill vpn", 64'(d_rvpn), 64'(m_req));
                chk(i_rvpn == m_req, "R3 refill vpn", 64'(i_rvpn), 64'(m_req));
            end

            hs_seen = d_rqv && refill_req_ready;
            if (hs_seen) hs_vpn = d_rvpn;
            if (rsp_valid) rsp_cnt++;

            flush    = maint_op || (ctl_wr != 6'd0);
            m_replay = 1'b0;
            case (m_st)
                0: if (req_valid && !mhit) begin m_st = 1; m_req = vpn; end
                1: if (refill_req_ready) m_st = 2;
                default: if (rsp_valid) begin
                    m_st = 0;
                    if (!flush) begin
                        int vi;
                        bit got;
                        vi = 0; got = 1'b0;
                        for (int i = 0; i < N; i++)
                            if (!got && !m_v[i]) begin vi = i; got = 1'b1; end
                        if (!got) begin vi = m_rr; m_rr = (m_rr + 1) % N; end
                        m_v[vi] = 1'b1; m_vpn[vi] = m_req; m_ppn[vi] = rsp_ppn;
                        m_dom[vi] = rsp_dom; m_ap[vi] = rsp_ap;
                        m_replay = 1'b1;
                    end
                end
            endcase
            if (flush) for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end
    end

    // one clock step; plays the backing store
    task automatic cyc();
        @(posedge clk);
        #1;
        maint_op = 1'b0; ctl_wr = 6'd0; refill_req_ready = 1'b0; rsp_valid = 1'b0;
        if (hs_seen) begin waiting = 1'b1; delay = int'($urandom % 3); end
        if (waiting) begin
            if (delay == 0) begin
                rsp_valid = 1'b1;
                rsp_ppn   = hs_vpn + 20'h5A000 + salt;
                rsp_dom   = hs_vpn[3:0] ^ salt[3:0];
                rsp_ap    = hs_vpn[7:4] ^ salt[7:4];
                waiting   = 1'b0;
                if (flush_on_rsp) begin ctl_wr = 6'b010000; flush_on_rsp = 1'b0; end
            end else begin
                delay--;
            end
        end else if (d_rqv) begin
            refill_req_ready = 1'($urandom % 2);
        end
    endtask

    // leaves at the negedge of the serving cycle
    task automatic access(input logic [VPN_W-1:0] vpn, input bit wr, input bit pr,
                          output bit missed);
        req_valid = 1'b1; req_va = {vpn, 12'h3A4}; req_write = wr; req_priv = pr;
        @(negedge clk); #1;
        missed = d_stall;
        for (int k = 0; k < 200; k++) begin
            if (d_rv) break;
            cyc();
            @(negedge clk); #1;
        end
    endtask

    task automatic done();
        cyc();
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        bit mi;
        int c0;
        rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_priv = 1'b0;
        dacr = 32'hFFFF_FFFF; maint_op = 1'b0; ctl_wr = 6'd0;
        refill_req_ready = 1'b0; rsp_valid = 1'b0; rsp_ppn = '0; rsp_dom = '0; rsp_ap = '0;
        waiting = 1'b0; delay = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(d_rqv == 1'b0, "R1 reset refill", 64'(d_rqv), 64'd0);
        chk(d_rv == 1'b0, "R1 reset resp", 64'(d_rv), 64'd0);
        @(posedge clk); #1; rst_n = 1'b1;
        cyc();

        // R1: empty after reset
        access(pool(0), 1'b0, 1'b1, mi);
        chk(mi == 1'b1, "R1 first miss", 64'(mi), 64'd1);
        done();
        // R12: fill and hit all slots
        for (int k = 1; k < N; k++) begin access(pool(k), 1'b0, 1'b1, mi); done(); end
        for (int k = 0; k < N; k++) begin
            access(pool(k), 1'b0, 1'b1, mi);
            chk(mi == 1'b0, "R12 resident", 64'(mi), 64'd0);
            done();
        end
        // R8: full table evicts slot 0, then slot 1
        access(pool(10), 1'b0, 1'b1, mi); done();
        access(pool(0), 1'b0, 1'b1, mi);
        chk(mi == 1'b1, "R8 evicted slot0", 64'(mi), 64'd1);
        done();
        access(pool(2), 1'b0, 1'b1, mi);
        chk(mi == 1'b0, "R8 slot2 kept", 64'(mi), 64'd0);
        done();
        // R9
        maint_op = 1'b1; cyc();
        access(pool(2), 1'b0, 1'b1, mi);
        chk(mi == 1'b1, "R9 maint flush", 64'(mi), 64'd1);
        done();
        // R10
        for (int b = 0; b < 6; b++) begin
            access(pool(3), 1'b0, 1'b1, mi); done();
            ctl_wr = 6'(1 << b); cyc();
            access(pool(3), 1'b0, 1'b1, mi);
            chk(mi == 1'b1, $sformatf("R10 ctl bit %0d", b), 64'(mi), 64'd1);
            done();
        end
        // R11
        c0 = rsp_cnt; flush_on_rsp = 1'b1;
        access(pool(5), 1'b0, 1'b1, mi);
        chk(rsp_cnt - c0 == 2, "R11 refill redone", 64'(rsp_cnt - c0), 64'd2);
        done();
        // R6 / R7: no-access domain
        dacr = 32'h0; ctl_wr = 6'b000010; cyc();
        access(pool(6), 1'b0, 1'b1, mi);
        chk(d_dab == 1'b1, "R6 no access", 64'(d_dab), 64'd1);
        chk(i_pab == 1'b1, "R7 pabort", 64'(i_pab), 64'd1);
        chk(i_dab == 1'b0, "R7 no dabort", 64'(i_dab), 64'd0);
        done();
        dacr = 32'hFFFF_FFFF; ctl_wr = 6'b000010; cyc();
        access(pool(6), 1'b1, 1'b0, mi);
        chk(d_dab == 1'b0, "R6 manager", 64'(d_dab), 64'd0);
        done();

        // random traffic against the reference
        dacr = 32'h5555_5555; ctl_wr = 6'b000010;
        for (int t = 0; t < 6000; t++) begin
            cyc();
            if (!(req_valid && d_stall)) begin
                req_valid = ($urandom % 4) != 0;
                req_va    = {pool(int'($urandom % 14)), 12'($urandom)};
                req_write = 1'($urandom);
                req_priv  = 1'($urandom);
            end
            if ($urandom % 40 == 0) maint_op = 1'b1;
            if ($urandom % 40 == 0) begin
                int b;
                b = int'($urandom % 6);
                ctl_wr[b] = 1'b1;
                if (b == 1) dacr = $urandom;
            end
            if ($urandom % 100 == 0) salt = 20'($urandom);
        end
        cyc();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule